// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical frame number after a translation cache miss. It keeps the physical base of the current process's page directory in a register that is reloaded on every context switch. A walk reads one directory entry, uses that entry's frame number to find the page table, and then reads one table entry. Each read goes through a read port with a valid/ready request handshake and a response strobe. Only one read is in flight at a time.

The virtual address splits into three fields. Bits 31:22 select one of 1024 directory entries. Bits 21:12 select one of 1024 table entries. Bits 11:0 are the byte offset. Every entry is 4 bytes wide. Its upper 20 bits are a frame number, and its low 12 bits are flags. Bit 0 of the flags is the valid bit.

A successful walk ends with a one-cycle done pulse that carries the table entry's frame number and flags, ready to fill the cache. The pulse also carries the full physical address. A clear valid bit at either level ends the walk with a one-cycle fault pulse that reports the level.

Top module: `xlat_walker`

## Requirements
- R1: The first read of a walk goes to address `base + vaddr[31:22]*4`, where `base` is the directory base register.
- R2: After a valid directory entry, the second read goes to address `pde[31:12]*4096 + vaddr[21:12]*4`.
- R3: When the table entry has bit 0 set, `done` is high for exactly one cycle, in the cycle after the response strobe. In that cycle `done_frame` equals `pte[31:12]` and `done_flags` equals `pte[11:0]`.
- R4: A directory entry with bit 0 clear gives a one-cycle `fault` with `fault_level`=0. No second read is issued and `done` stays low.
- R5: A table entry with bit 0 clear gives a one-cycle `fault` with `fault_level`=1, and `done` stays low.
- R6: `base_load` copies `base_addr` into the directory base register. A walk uses the base value held when its request was accepted, so a load during a walk takes effect only from the next walk.
- R7: `req_ready` is high only while idle. A request presented while a walk is in progress is not taken and does not change that walk.
- R8: `mem_rd_valid` holds its address steady until `mem_rd_ready`. After the handshake it stays low until the response arrives, so at most one read is outstanding.
- R9: A response strobe that arrives while no read is outstanding produces neither `done` nor `fault`.
- R10: While reset is asserted, `req_ready`=1, `mem_rd_valid`=0, `done`=0 and `fault`=0.
- R11: The byte offset `vaddr[11:0]` has no effect on the reads. It is passed through as `done_paddr = {pte[31:12], vaddr[11:0]}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_load | input | 1 | Load strobe for the directory base register |
| base_addr | input | 32 | New directory base physical address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Physical address of the entry being read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle successful completion pulse |
| done_frame | output | 20 | Frame number from the table entry |
| done_flags | output | 12 | Flag bits from the table entry |
| done_paddr | output | 32 | Frame number joined with the byte offset |
| fault | output | 1 | One-cycle page fault pulse |
| fault_level | output | 1 | Level of the fault: 0 directory, 1 table |

## Verification
A table of walks covers several patterns, and each one separates a different kind of error:
- The lowest and highest indices at both levels (0/0 and 1023/1023) expose index slicing and scaling errors.
- A directory entry with every flag set except bit 0 shows that only bit 0 gates the walk.
- A table entry of all ones except bit 0 does the same at the second level.
- Two walks through the same page table with different offsets separate table-index handling from offset handling.

Each walk uses a different request stall and response latency from the memory. Directed tests then cover:
- the reset state;
- a stray response strobe while idle;
- a base reload in the middle of a walk, followed by a walk that uses the new base;
- a competing request held during a walk.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DIR_REQ  = 3'd1,
    ST_DIR_WAIT = 3'd2,
    ST_TBL_REQ  = 3'd3,
    ST_TBL_WAIT = 3'd4
  } walk_state_e;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } walk_level_e;

endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  // assert asynchronously, release after STAGES clock edges
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/xlat_base_reg.sv
module xlat_base_reg #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [PA_W-1:0] load_val,
  output logic [PA_W-1:0] base_q
);

  logic [PA_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (load_en) begin
      base_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else begin
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int OFS_W     = 12,
  parameter int IDX_W     = 10,
  parameter int FRAME_W   = 20,
  parameter int ENT_SHIFT = 2
) (
  input  logic [FRAME_W+OFS_W-1:0] base,
  input  logic [IDX_W-1:0]         dir_idx,
  input  logic [IDX_W-1:0]         tbl_idx,
  input  logic [FRAME_W-1:0]       pde_frame,
  output logic [FRAME_W+OFS_W-1:0] dir_addr,
  output logic [FRAME_W+OFS_W-1:0] tbl_addr
);

  localparam int PA_W  = FRAME_W + OFS_W;
  localparam int PAD_W = PA_W - IDX_W - ENT_SHIFT;

  logic [PA_W-1:0] dir_ofs;
  logic [PA_W-1:0] tbl_ofs;
  logic [PA_W-1:0] tbl_page;

  // each index is scaled by the entry size (1 << ENT_SHIFT bytes)
  assign dir_ofs  = {{PAD_W{1'b0}}, dir_idx, {ENT_SHIFT{1'b0}}};
  assign tbl_ofs  = {{PAD_W{1'b0}}, tbl_idx, {ENT_SHIFT{1'b0}}};
  assign tbl_page = {pde_frame, {OFS_W{1'b0}}};

  assign dir_addr = base + dir_ofs;
  assign tbl_addr = tbl_page + tbl_ofs;

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int OFS_W     = 12,
  parameter int IDX_W     = 10,
  parameter int FRAME_W   = 20,
  parameter int VALID_BIT = 0,
  localparam int PA_W     = FRAME_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IDX_W-1:0]   req_tbl_idx,
  input  logic [OFS_W-1:0]   req_ofs,
  output logic [IDX_W-1:0]   walk_tbl_idx,
  input  logic [PA_W-1:0]    dir_addr,
  input  logic [PA_W-1:0]    tbl_addr,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [PA_W-1:0]    mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [PA_W-1:0]    mem_rsp_data,
  output logic               done,
  output logic [FRAME_W-1:0] done_frame,
  output logic [OFS_W-1:0]   done_flags,
  output logic [PA_W-1:0]    done_paddr,
  output logic               fault,
  output logic               fault_level
);

  walk_state_e        state_q, state_d;
  logic [PA_W-1:0]    addr_q, addr_d;
  logic [IDX_W-1:0]   tidx_q;
  logic [OFS_W-1:0]   ofs_q;
  logic               accept;
  logic               done_d, fault_d, fin_en;
  walk_level_e        lvl_d;
  logic               entry_ok;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign entry_ok = mem_rsp_data[VALID_BIT];

  // next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    fin_en  = 1'b0;
    lvl_d   = LVL_DIR;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_DIR_REQ;
          addr_d  = dir_addr;
        end
      end
      ST_DIR_REQ: begin
        if (mem_rd_ready) state_d = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        if (mem_rsp_valid) begin
          if (entry_ok) begin
            state_d = ST_TBL_REQ;
            addr_d  = tbl_addr;
          end else begin
            state_d = ST_IDLE;
            fault_d = 1'b1;
            fin_en  = 1'b1;
            lvl_d   = LVL_DIR;
          end
        end
      end
      ST_TBL_REQ: begin
        if (mem_rd_ready) state_d = ST_TBL_WAIT;
      end
      ST_TBL_WAIT: begin
        if (mem_rsp_valid) begin
          state_d = ST_IDLE;
          fin_en  = 1'b1;
          lvl_d   = LVL_TBL;
          if (entry_ok) done_d  = 1'b1;
          else          fault_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state and walk context registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      tidx_q  <= '0;
      ofs_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      if (accept) begin
        tidx_q <= req_tbl_idx;
        ofs_q  <= req_ofs;
      end
    end
  end

  // completion registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_level <= 1'b0;
      done_frame  <= '0;
      done_flags  <= '0;
      done_paddr  <= '0;
    end else begin
      done  <= done_d;
      fault <= fault_d;
      if (fin_en) begin
        fault_level <= lvl_d;
        done_frame  <= mem_rsp_data[PA_W-1 -: FRAME_W];
        done_flags  <= mem_rsp_data[OFS_W-1:0];
        done_paddr  <= {mem_rsp_data[PA_W-1 -: FRAME_W], ofs_q};
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
  assign mem_rd_addr  = addr_q;
  assign walk_tbl_idx = tidx_q;

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rsp_valid));

  assert_fault_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  assert_done_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fault);

  assert_idle_rsp_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && mem_rsp_valid) |=> !(done || fault));

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int OFS_W       = 12,
  parameter int IDX_W       = 10,
  parameter int FRAME_W     = 20,
  parameter int ENT_SHIFT   = 2,
  parameter int VALID_BIT   = 0,
  parameter int SYNC_STAGES = 2,
  localparam int VA_W       = OFS_W + 2 * IDX_W,
  localparam int PA_W       = FRAME_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_load,
  input  logic [PA_W-1:0]    base_addr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [PA_W-1:0]    mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [PA_W-1:0]    mem_rsp_data,
  output logic               done,
  output logic [FRAME_W-1:0] done_frame,
  output logic [OFS_W-1:0]   done_flags,
  output logic [PA_W-1:0]    done_paddr,
  output logic               fault,
  output logic               fault_level
);

  localparam int TBL_LSB = OFS_W;
  localparam int DIR_LSB = OFS_W + IDX_W;

  logic              rst_n_s;
  logic [PA_W-1:0]   base_q;
  logic [PA_W-1:0]   dir_addr;
  logic [PA_W-1:0]   tbl_addr;
  logic [IDX_W-1:0]  walk_tbl_idx;

  xlat_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  xlat_base_reg #(.PA_W(PA_W)) u_base_reg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_en  (base_load),
    .load_val (base_addr),
    .base_q   (base_q)
  );

  xlat_addr_gen #(
    .OFS_W     (OFS_W),
    .IDX_W     (IDX_W),
    .FRAME_W   (FRAME_W),
    .ENT_SHIFT (ENT_SHIFT)
  ) u_addr_gen (
    .base      (base_q),
    .dir_idx   (req_vaddr[DIR_LSB +: IDX_W]),
    .tbl_idx   (walk_tbl_idx),
    .pde_frame (mem_rsp_data[PA_W-1 -: FRAME_W]),
    .dir_addr  (dir_addr),
    .tbl_addr  (tbl_addr)
  );

  xlat_ctrl #(
    .OFS_W     (OFS_W),
    .IDX_W     (IDX_W),
    .FRAME_W   (FRAME_W),
    .VALID_BIT (VALID_BIT)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_tbl_idx   (req_vaddr[TBL_LSB +: IDX_W]),
    .req_ofs       (req_vaddr[OFS_W-1:0]),
    .walk_tbl_idx  (walk_tbl_idx),
    .dir_addr      (dir_addr),
    .tbl_addr      (tbl_addr),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .done_frame    (done_frame),
    .done_flags    (done_flags),
    .done_paddr    (done_paddr),
    .fault         (fault),
    .fault_level   (fault_level)
  );

endmodule

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_load = 1'b0;
  logic [31:0] base_addr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [19:0] done_frame;
  logic [11:0] done_flags;
  logic [31:0] done_paddr;
  logic        fault;
  logic        fault_level;

  always #5 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_addr(base_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .done_frame(done_frame), .done_flags(done_flags), .done_paddr(done_paddr),
    .fault(fault), .fault_level(fault_level)
  );

  localparam logic [31:0] BASE0 = 32'h0010_0000;
  localparam logic [31:0] BASE1 = 32'h0020_0800;

  // kind: 0 translated, 1 directory fault, 2 table fault
  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic [19:0] frame;
    logic [11:0] flags;
    logic [3:0]  stall;
    logic [3:0]  lat;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{va:32'h0040_3ABC, kind:2'd0, frame:20'hABCDE, flags:12'h067, stall:4'd0, lat:4'd0},
    '{va:32'hFFFF_F000, kind:2'd0, frame:20'h12345, flags:12'hFFF, stall:4'd2, lat:4'd3},
    '{va:32'h0000_0123, kind:2'd0, frame:20'h00000, flags:12'h001, stall:4'd1, lat:4'd1},
    '{va:32'h0080_0000, kind:2'd1, frame:20'h00000, flags:12'h000, stall:4'd0, lat:4'd2},
    '{va:32'h0040_5000, kind:2'd2, frame:20'h00000, flags:12'h000, stall:4'd3, lat:4'd0},
    '{va:32'h0040_4FFF, kind:2'd0, frame:20'h00777, flags:12'h021, stall:4'd0, lat:4'd5}
  };

  logic [31:0] mem_img [logic [31:0]];
  int          n_chk = 0;
  int          n_fail = 0;
  int          rsp_stall = 0;
  int          rsp_lat = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_log [4];
  logic        got_done, got_fault, got_lvl, busy_ready;
  logic [19:0] got_frame;
  logic [11:0] got_flags;
  logic [31:0] got_paddr;
  logic        finished = 1'b0;

  function automatic logic [31:0] lookup(input logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_valid && rst_n) begin
        repeat (rsp_stall) @(negedge clk);
        mem_rd_ready = 1'b1;
        if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
        rd_cnt++;
        mem_rsp_data = lookup(mem_rd_addr);
        @(negedge clk);
        mem_rd_ready = 1'b0;
        repeat (rsp_lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic pulse_base(input logic [31:0] b);
    base_addr = b;
    base_load = 1'b1;
    @(negedge clk);
    base_load = 1'b0;
  endtask

  // start a walk at a negedge while idle; poke holds a competing request,
  // reload loads BASE1 during the walk
  task automatic run_walk(input logic [31:0] va, input bit poke, input bit reload);
    bit got;
    rd_cnt = 0;
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ready = req_ready;
    if (poke) begin
      req_vaddr = 32'hFFC0_0000;
      req_valid = 1'b1;
      @(negedge clk);
      busy_ready = busy_ready | req_ready;
      req_valid = 1'b0;
    end
    if (reload) pulse_base(BASE1);
    got = 0;
    got_done = 0;
    got_fault = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      if (done || fault) begin
        got = 1;
        got_done = done;
        got_fault = fault;
        got_lvl = fault_level;
        got_frame = done_frame;
        got_flags = done_flags;
        got_paddr = done_paddr;
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    chk("R3 pulse width done", {63'b0, done}, 64'd0);
    chk("R4 pulse width fault", {63'b0, fault}, 64'd0);
  endtask

  initial begin
    logic [31:0] pde, pte, pde_a, pte_a;
    mem_img[32'h0010_0004] = 32'h0020_0001;
    mem_img[32'h0020_000C] = 32'hABCD_E067;
    mem_img[32'h0010_0FFC] = 32'h0030_0003;
    mem_img[32'h0030_0FFC] = 32'h1234_5FFF;
    mem_img[32'h0010_0000] = 32'h0040_0001;
    mem_img[32'h0040_0000] = 32'h0000_0001;
    mem_img[32'h0010_0008] = 32'h0050_0FFE;
    mem_img[32'h0020_0014] = 32'hFFFF_FFFE;
    mem_img[32'h0020_0010] = 32'h0077_7021;
    mem_img[32'h0020_0804] = 32'h0060_0001;
    mem_img[32'h0060_000C] = 32'h0BEE_F003;

    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 req_ready in reset", {63'b0, req_ready}, 64'd1);
    chk("R10 mem_rd_valid in reset", {63'b0, mem_rd_valid}, 64'd0);
    chk("R10 done in reset", {63'b0, done}, 64'd0);
    chk("R10 fault in reset", {63'b0, fault}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pulse_base(BASE0);
    @(negedge clk);

    // table-driven walks
    for (int v = 0; v < NVEC; v++) begin
      rsp_stall = int'(VEC[v].stall);
      rsp_lat   = int'(VEC[v].lat);
      pde_a = BASE0 + {20'b0, VEC[v].va[31:22], 2'b00};
      pde   = lookup(pde_a);
      pte_a = {pde[31:12], 12'h000} + {20'b0, VEC[v].va[21:12], 2'b00};
      pte   = lookup(pte_a);
      run_walk(VEC[v].va, 0, 0);
      chk("R7 req_ready low while busy", {63'b0, busy_ready}, 64'd0);
      chk("R1 directory read address", {32'b0, rd_log[0]}, {32'b0, pde_a});
      if (VEC[v].kind == 2'd1) begin
        chk("R4 single read on directory fault", rd_cnt, 1);
        chk("R4 fault raised", {62'b0, got_fault, got_done}, 64'd2);
        chk("R4 fault level", {63'b0, got_lvl}, 64'd0);
      end else begin
        chk("R8 two reads per walk", rd_cnt, 2);
        chk("R2 table read address", {32'b0, rd_log[1]}, {32'b0, pte_a});
        if (VEC[v].kind == 2'd2) begin
          chk("R5 fault raised", {62'b0, got_fault, got_done}, 64'd2);
          chk("R5 fault level", {63'b0, got_lvl}, 64'd1);
        end else begin
          chk("R3 done raised", {62'b0, got_fault, got_done}, 64'd1);
          chk("R3 frame", {44'b0, got_frame}, {44'b0, VEC[v].frame});
          chk("R3 flags", {52'b0, got_flags}, {52'b0, VEC[v].flags});
          chk("R3 frame matches entry", {44'b0, got_frame}, {44'b0, pte[31:12]});
          chk("R11 physical address", {32'b0, got_paddr},
              {32'b0, VEC[v].frame, VEC[v].va[11:0]});
        end
      end
      @(negedge clk);
    end

    // R9 stray response while idle
    rsp_stall = 0;
    rsp_lat = 1;
    mem_rsp_data = 32'h1111_1001;
    mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R9 no done after stray response", {63'b0, done}, 64'd0);
      chk("R9 no fault after stray response", {63'b0, fault}, 64'd0);
      @(negedge clk);
    end
    chk("R9 still idle", {62'b0, req_ready, mem_rd_valid}, 64'd2);

    // R7 competing request held during a walk
    run_walk(32'h0040_3ABC, 1, 0);
    chk("R7 busy request not taken", {63'b0, busy_ready}, 64'd0);
    chk("R7 walk unchanged", {44'b0, got_frame}, {44'b0, 20'hABCDE});
    chk("R7 read count", rd_cnt, 2);
    repeat (20) @(negedge clk);
    chk("R7 no late walk from busy request", {62'b0, req_ready, mem_rd_valid}, 64'd2);

    // R6 base reload mid-walk, then walk with new base
    rsp_lat = 4;
    run_walk(32'h0040_3ABC, 0, 1);
    chk("R6 walk keeps old base", {32'b0, rd_log[0]}, {32'b0, 32'h0010_0004});
    chk("R6 walk result with old base", {44'b0, got_frame}, {44'b0, 20'hABCDE});
    @(negedge clk);
    run_walk(32'h0040_3000, 0, 0);
    chk("R6 new base directory address", {32'b0, rd_log[0]}, {32'b0, 32'h0020_0804});
    chk("R6 new base table address", {32'b0, rd_log[1]}, {32'b0, 32'h0060_000C});
    chk("R6 new base result", {44'b0, got_frame}, {44'b0, 20'h0BEEF});
    chk("R6 new base flags", {52'b0, got_flags}, {52'b0, 12'h003});

    report();
  end

endmodule